// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage, 32-bit integer pipeline. It finds the cases where an operand of the instruction now executing is still waiting to be written back by one of the two instructions ahead of it. For each such operand it takes the newer copy of the value from the pipeline registers, so the instruction does not read a stale register-file value. It compares the two source register numbers of the executing instruction with the destination numbers and write enables of the memory-stage and write-back-stage instructions. It then drives a 2-bit select code for each ALU operand and the two 3-input operand multiplexers that the codes control.

A third, 1-bit select serves the data-memory write path. When a load is followed directly by a store of the loaded register, the store reaches the memory stage while the load sits in write-back. The loaded value is then routed to the store's write data, so a memory-to-memory copy needs no stall. A match on the store's address register is a load-use case and belongs to the stall logic, not to this block.

Register zero always reads as zero and is never bypassed. When both later stages write the same register, the memory-stage result, being the newer one, wins. The block is purely combinational.

Top module: `fwd_unit`

## Requirements
- R1: When no bypass condition holds for an operand, its select is 00 and the operand output carries the register-file value read in decode.
- R2: An operand's select is 10 (memory-stage ALU result) when the memory-stage write enable is 1, its destination number is nonzero, and it equals that operand's source number (rs for operand A, rt for operand B).
- R3: An operand's select is 01 (write-back value) when the write-back write enable is 1, its destination is nonzero and equals the operand's source number, and the select for that operand is not 10.
- R4: When both later stages have a live write to the same nonzero register that an operand reads, that operand's select is 10, so the newer result wins.
- R5: A destination number of zero never produces a bypass, even when it matches the source number.
- R6: A matching destination whose write enable is 0 never produces a bypass.
- R7: Each operand output equals the register-file value, the memory-stage ALU result or the write-back value for select 00, 10 or 01. The code 11 is never produced.
- R8: The store-data select is 1 exactly when the memory-stage instruction is a store, the write-back instruction has write enable 1 and comes from a load, its destination is nonzero, and that destination equals the store's rt. When it is 1, the store write data equals the write-back value.
- R9: In every other case the store-data select is 0 and the store write data is the store's own data from the memory-stage register. This includes a write-back from a non-load and a write-back to a register other than rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register number of the executing instruction |
| ex_rt | input | 5 | Second source register number of the executing instruction |
| ex_rs_val | input | 32 | Register-file value read for the first source |
| ex_rt_val | input | 32 | Register-file value read for the second source |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | 5 | Memory-stage destination register number |
| mem_alu | input | 32 | Memory-stage ALU result |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_st_rt | input | 5 | Register number supplying the store's data |
| mem_st_val | input | 32 | Store data held in the memory-stage register |
| wb_we | input | 1 | Write-back instruction writes a register |
| wb_load | input | 1 | Write-back value comes from data memory |
| wb_rd | input | 5 | Write-back destination register number |
| wb_val | input | 32 | Value being written back |
| sel_a | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 write-back |
| sel_b | output | 2 | Operand B select, same encoding |
| sel_st | output | 1 | Store data select: 1 takes the write-back value |
| opnd_a | output | 32 | ALU operand A |
| opnd_b | output | 32 | ALU operand B |
| st_wdata | output | 32 | Data-memory write data |

## Verification
The assertions assume that all inputs hold known two-state values that have settled before they are sampled. They also assume that each stage's control bits belong to one consistent instruction. The bench drives every input to a defined value at all times and changes all of them together. Register numbers are drawn from a narrow range that includes zero, so matches, zero destinations and double matches occur often, while the write enables, the load flag and the store flag are drawn freely.

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic [DW-1:0] ex_rs_val,
  input  logic [DW-1:0] ex_rt_val,
  input  logic          mem_we,
  input  logic [RW-1:0] mem_rd,
  input  logic [DW-1:0] mem_alu,
  input  logic          mem_store,
  input  logic [RW-1:0] mem_st_rt,
  input  logic [DW-1:0] mem_st_val,
  input  logic          wb_we,
  input  logic          wb_load,
  input  logic [RW-1:0] wb_rd,
  input  logic [DW-1:0] wb_val,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          sel_st,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  output logic [DW-1:0] st_wdata
);
  localparam logic [1:0] PICK_RF = 2'b00;
  localparam logic [1:0] PICK_WB = 2'b01;
  localparam logic [1:0] PICK_EX = 2'b10;
  localparam int NOPS = 2;

  logic mem_live, wb_live;
  assign mem_live = mem_we && (mem_rd != '0);
  assign wb_live  = wb_we  && (wb_rd  != '0);

  logic [NOPS-1:0][RW-1:0] src;
  logic [NOPS-1:0][DW-1:0] rf_val;
  logic [NOPS-1:0][1:0]    pick;
  logic [NOPS-1:0][DW-1:0] val;

  assign src    = {ex_rt, ex_rs};
  assign rf_val = {ex_rt_val, ex_rs_val};

  for (genvar i = 0; i < NOPS; i++) begin : g_opnd
    logic hit_mem, hit_wb;
    assign hit_mem = mem_live && (mem_rd == src[i]);
    assign hit_wb  = wb_live  && (wb_rd  == src[i]);
    assign pick[i] = hit_mem ? PICK_EX : (hit_wb ? PICK_WB : PICK_RF);
    always_comb begin
      unique case (pick[i])
        PICK_EX: val[i] = mem_alu;
        PICK_WB: val[i] = wb_val;
        default: val[i] = rf_val[i];
      endcase
    end
  end

  assign sel_a  = pick[0];
  assign sel_b  = pick[1];
  assign opnd_a = val[0];
  assign opnd_b = val[1];

  assign sel_st   = mem_store && wb_live && wb_load && (wb_rd == mem_st_rt);
  assign st_wdata = sel_st ? wb_val : mem_st_val;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input logic [RW-1:0] ex_rs,
  input logic [RW-1:0] ex_rt,
  input logic [DW-1:0] ex_rs_val,
  input logic [DW-1:0] ex_rt_val,
  input logic          mem_we,
  input logic [RW-1:0] mem_rd,
  input logic [DW-1:0] mem_alu,
  input logic          mem_store,
  input logic [RW-1:0] mem_st_rt,
  input logic [DW-1:0] mem_st_val,
  input logic          wb_we,
  input logic          wb_load,
  input logic [RW-1:0] wb_rd,
  input logic [DW-1:0] wb_val,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic          sel_st,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b,
  input logic [DW-1:0] st_wdata
);
  always_comb begin
    assert_ex_path_a_R2: assert (sel_a != 2'b10 || (mem_we && mem_rd != '0 && mem_rd == ex_rs))
      else $error("operand A took memory-stage path without a live match");
    assert_ex_path_b_R2: assert (sel_b != 2'b10 || (mem_we && mem_rd != '0 && mem_rd == ex_rt))
      else $error("operand B took memory-stage path without a live match");
    assert_newest_a_R4: assert (!(mem_we && wb_we && mem_rd == wb_rd && mem_rd == ex_rs && ex_rs != '0) || sel_a == 2'b10)
      else $error("operand A did not favour the newer result");
    assert_newest_b_R4: assert (!(mem_we && wb_we && mem_rd == wb_rd && mem_rd == ex_rt && ex_rt != '0) || sel_b == 2'b10)
      else $error("operand B did not favour the newer result");
    assert_zero_src_R5: assert (ex_rs != '0 || sel_a == 2'b00)
      else $error("register zero bypassed on operand A");
    assert_quiet_R6: assert ((mem_we || wb_we) || (sel_a == 2'b00 && sel_b == 2'b00))
      else $error("bypass with no writer");
    assert_no_code3_R7: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("reserved select code");
    assert_mux_a_R7: assert (opnd_a == (sel_a == 2'b10 ? mem_alu : (sel_a == 2'b01 ? wb_val : ex_rs_val)))
      else $error("operand A mux mismatch");
    assert_st_src_R8: assert (!sel_st || (mem_store && wb_load && wb_we && wb_rd == mem_st_rt && wb_rd != '0))
      else $error("store bypass without a load match");
    assert_st_keep_R9: assert (sel_st || st_wdata == mem_st_val)
      else $error("store data altered without bypass");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.RW(RW), .DW(DW)) u_chk (.*);

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;
  localparam int DW = 32;
  localparam int NRAND = 3000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [RW-1:0] ex_rs, ex_rt, mem_rd, mem_st_rt, wb_rd;
  logic [DW-1:0] ex_rs_val, ex_rt_val, mem_alu, mem_st_val, wb_val;
  logic mem_we, mem_store, wb_we, wb_load;
  logic [1:0] sel_a, sel_b;
  logic sel_st;
  logic [DW-1:0] opnd_a, opnd_b, st_wdata;

  fwd_unit #(.RW(RW), .DW(DW)) u_fwd_unit (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [1:0] ref_sel(input logic [RW-1:0] s);
    if (mem_we && mem_rd != 0 && mem_rd == s) return 2'b10;
    if (wb_we && wb_rd != 0 && wb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] ref_val(input logic [1:0] p, input logic [DW-1:0] rf);
    return p == 2'b10 ? mem_alu : (p == 2'b01 ? wb_val : rf);
  endfunction

  function automatic logic ref_st();
    return mem_store && wb_we && wb_load && wb_rd != 0 && wb_rd == mem_st_rt;
  endfunction

  function automatic string tag_of(input logic [RW-1:0] s);
    bit mh = mem_we && mem_rd != 0 && mem_rd == s;
    bit wh = wb_we && wb_rd != 0 && wb_rd == s;
    if (mh && wh) return "R4";
    if (mh) return "R2";
    if (wh) return "R3";
    if ((mem_rd == s || wb_rd == s) && s == 0) return "R5";
    if (mem_rd == s || wb_rd == s) return "R6";
    return "R1";
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic [1:0] ea = ref_sel(ex_rs);
    logic [1:0] eb = ref_sel(ex_rt);
    logic es = ref_st();
    #(CLK_PERIOD/2);
    chk(tag_of(ex_rs), "sel_a", DW'(sel_a), DW'(ea));
    chk(tag_of(ex_rt), "sel_b", DW'(sel_b), DW'(eb));
    chk("R7", "opnd_a", opnd_a, ref_val(ea, ex_rs_val));
    chk("R7", "opnd_b", opnd_b, ref_val(eb, ex_rt_val));
    chk(es ? "R8" : "R9", "sel_st", DW'(sel_st), DW'(es));
    chk(es ? "R8" : "R9", "st_wdata", st_wdata, es ? wb_val : mem_st_val);
    #(CLK_PERIOD/2);
  endtask

  task automatic set_data();
    ex_rs_val = $urandom; ex_rt_val = $urandom; mem_alu = $urandom;
    mem_st_val = $urandom; wb_val = $urandom;
  endtask

  task automatic drive(input logic [RW-1:0] rs, input logic [RW-1:0] rt,
                       input logic mwe, input logic [RW-1:0] mrd,
                       input logic mst, input logic [RW-1:0] mrt,
                       input logic wwe, input logic wld, input logic [RW-1:0] wrd);
    ex_rs = rs; ex_rt = rt; mem_we = mwe; mem_rd = mrd; mem_store = mst;
    mem_st_rt = mrt; wb_we = wwe; wb_load = wld; wb_rd = wrd;
    set_data();
    check_all();
  endtask

  initial begin
    void'($urandom(32'd421));
    ex_rs = '0; ex_rt = '0; mem_rd = '0; mem_st_rt = '0; wb_rd = '0;
    mem_we = 0; mem_store = 0; wb_we = 0; wb_load = 0;
    ex_rs_val = 32'h1111_0001; ex_rt_val = 32'h2222_0002; mem_alu = 32'h3333_0003;
    mem_st_val = 32'h4444_0004; wb_val = 32'h5555_0005;
    @(negedge clk);
    check_all();                                   // R1 idle state
    drive(5'd2, 5'd3, 1, 5'd2, 0, 0, 0, 0, 5'd0);  // R2 operand A from memory stage
    drive(5'd4, 5'd2, 0, 5'd0, 0, 0, 1, 0, 5'd2);  // R3 operand B from write-back
    drive(5'd1, 5'd1, 1, 5'd1, 0, 0, 1, 0, 5'd1);  // R4 both stages write r1
    drive(5'd0, 5'd0, 1, 5'd0, 0, 0, 1, 1, 5'd0);  // R5 zero destination
    drive(5'd6, 5'd6, 0, 5'd6, 0, 0, 0, 1, 5'd6);  // R6 matches without enable
    drive(5'd7, 5'd9, 0, 5'd7, 0, 0, 1, 0, 5'd7);  // R3 memory stage not writing
    drive(5'd8, 5'd8, 0, 5'd0, 1, 5'd8, 1, 1, 5'd8); // R8 load then store
    drive(5'd3, 5'd3, 0, 5'd0, 1, 5'd8, 1, 0, 5'd8); // R9 write-back not a load
    drive(5'd3, 5'd3, 0, 5'd0, 1, 5'd0, 1, 1, 5'd0); // R9 zero register
    drive(5'd3, 5'd3, 0, 5'd0, 0, 5'd8, 1, 1, 5'd8); // R9 no store
    for (int n = 0; n < NRAND; n++) begin
      ex_rs = RW'($urandom_range(0, 3));
      ex_rt = RW'($urandom_range(0, 3));
      mem_rd = RW'($urandom_range(0, 3));
      wb_rd = RW'($urandom_range(0, 3));
      mem_st_rt = RW'($urandom_range(0, 3));
      mem_we = 1'($urandom); wb_we = 1'($urandom);
      wb_load = 1'($urandom); mem_store = 1'($urandom);
      set_data();
      check_all();
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule